// File: doc/BRIEF.md
# SPI Controller with Error Flags

This block is an 8-bit serial peripheral interface controller that works either as the clock-driving master or as a selected slave. Software reaches it through three registers (control, status and received data) over a simple strobe interface: a two-bit register select, a write strobe, a read strobe and a combinational read bus. Bits go out most significant first. Clock polarity and clock phase are picked by two control bits. In master mode the serial clock half period lasts a fixed number of system clocks.

The status logic is the main feature. It holds a byte-complete flag, a mode-fault flag, a write-collision flag and a slave-deselect error flag. Each flag has its own rule for being set and its own rule for being cleared. Three of them clear only through an ordered pair of register accesses, and the fourth clears only when the block is disabled. A mode fault takes the controller out of enabled master operation. A select-ignore control bit masks the select pin, and with it the mode fault.

The controller drives two interrupt lines. One follows byte completion. The other follows the mode fault, but only while the select pin is not being ignored.

Top module: `spi_err_ctrl`

## Requirements
- R1: After reset, the control register, the status register and the receive buffer read 0, both interrupt outputs are low and `sck_o` is low.
- R2: Register select 0 is control, with bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase and bit 4 select-ignore. Select 1 is status, with bit 0 byte-complete, bit 1 mode-fault, bit 2 write-collision and bit 3 deselect-error. Select 2 is the data register. Unused upper bits of control and status read 0, and written upper control bits are dropped.
- R3: In enabled master mode, a data write while idle sends the byte MSB first over 16 clock edges, each half period lasting DIV_HALF system clocks. `sck_o` idles at the polarity bit. With phase 0, data is sampled on the edge leaving the idle level; with phase 1, it is sampled on the edge returning to it.
- R4: In enabled slave mode, while `ss_n_i` is low, the byte written earlier is shifted out on `sdo` and a byte is taken from `sdi` under the same bit order and edge rules as R3. The byte is complete after its eighth sample.
- R5: The byte-complete flag is set at the end of every byte and drives `irq_done`. It clears only on a data read or data write that follows a status read which saw the flag set.
- R6: In enabled master mode with select-ignore 0, a low `ss_n_i` sets the mode-fault flag, clears the enable and master bits, and raises `irq_err`.
- R7: The mode-fault flag clears only on a control write that follows a status read which saw the flag set. A control write without that read leaves the flag set.
- R8: With select-ignore 1, a low `ss_n_i` never sets mode fault or raises `irq_err`, and a master transfer completes normally.
- R9: A data write during a transfer sets the write-collision flag, raises no interrupt and leaves the ongoing byte unchanged. The flag clears on a data access that follows a status read which saw it set.
- R10: In slave mode, `ss_n_i` rising after 1 to 7 bits of a byte sets the deselect-error flag with no interrupt. Deselecting after 0 or 8 bits does not set it. The flag stays set until enable is written 0.
- R11: Bytes that complete while the byte-complete flag is set are discarded. The receive buffer keeps the first byte after the last clear, and no further status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the clear sequences) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register |
| sck_i | input | 1 | Serial clock input used in slave mode |
| ss_n_i | input | 1 | Active-low select input |
| sdi | input | 1 | Serial data input |
| sck_o | output | 1 | Serial clock output in master mode |
| sdo | output | 1 | Serial data output |
| irq_done | output | 1 | Byte-complete interrupt request |
| irq_err | output | 1 | Mode-fault interrupt request |

## Verification
The bench builds the block with DW=8, DIV_HALF=2 and SYNC_STAGES=2. The short master half period keeps a loopback byte to about 32 clocks, which leaves room for many random bytes across all four polarity and phase combinations. The bench acts as slave-side master with a half period of 6 clocks. That is longer than the two-stage synchronizer delay, so a partial byte, a full byte and back-to-back bytes with the complete flag still set can all be placed at exact bit counts.

// File: rtl/spi_err_pkg.sv
// Shared register selects and register layouts for the SPI controller.
package spi_err_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2
    } reg_sel_e;

    // Control layout, LSB last: bit0 en, bit1 master, bit2 cpol, bit3 cpha, bit4 ss_ign.
    typedef struct packed {
        logic ss_ign;
        logic cpha;
        logic cpol;
        logic master;
        logic en;
    } ctrl_t;

    // Status layout: bit0 done, bit1 mfault, bit2 wcol, bit3 sserr.
    typedef struct packed {
        logic sserr;
        logic wcol;
        logic mfault;
        logic done;
    } stat_t;
endpackage

// File: rtl/spi_err_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes inputs change slowly compared to clk; adds STAGES cycles of latency.
module spi_err_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    // Shift the pin values through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_err_engine.sv
// Shift engine: master clock generation, slave edge detection, MSB-first
// shifting and byte completion. It is held in reset while enable is 0.
// Assumes the slave clock and select inputs are already synchronized.
module spi_err_engine
    import spi_err_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DIV_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic          ld,
    input  logic [DW-1:0] ld_data,
    input  logic          sck_s,
    input  logic          ss_s,
    input  logic          sdi,
    output logic          sck_o,
    output logic          sdo,
    output logic          busy,
    output logic          done_pulse,
    output logic          ss_abort,
    output logic [DW-1:0] rx_out
);
    localparam int BW  = $clog2(DW);
    localparam int EW  = $clog2(2 * DW);
    localparam int DVW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [DW-1:0]  tx_sr, rx_sr, rx_next;
    logic [BW-1:0]  bitcnt;
    logic [EW-1:0]  ecnt;
    logic [DVW-1:0] divcnt;
    logic m_busy, sck_lvl, sck_prev, ss_prev;
    logic slave_mode, selected, tick, lead, trail, s_edge;
    logic sample_now, shift_now, last_bit, finish;

    assign slave_mode = ctrl.en & ~ctrl.master;
    assign selected   = slave_mode & (ctrl.ss_ign | ~ss_s);
    assign tick       = m_busy && (divcnt == DVW'(DIV_HALF - 1));
    assign s_edge     = selected && (sck_s != sck_prev);
    assign lead       = (tick && !ecnt[0]) || (s_edge && (sck_s != ctrl.cpol));
    assign trail      = (tick && ecnt[0])  || (s_edge && (sck_s == ctrl.cpol));
    assign sample_now = ctrl.cpha ? trail : lead;
    assign shift_now  = ctrl.cpha ? (lead && bitcnt != '0) : trail;
    assign rx_next    = {rx_sr[DW-2:0], sdi};
    assign last_bit   = sample_now && (bitcnt == BW'(DW - 1));
    assign finish     = ctrl.master ? (tick && ecnt == EW'(2 * DW - 1)) : last_bit;
    assign busy       = m_busy | selected;
    assign sck_o      = ctrl.cpol ^ sck_lvl;
    assign sdo        = tx_sr[DW-1];

    // Track previous synchronized clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            ss_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            ss_prev  <= ss_s;
        end
    end

    // Transfer state: load, clock division, shifting, sampling, completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl.en) begin
            tx_sr      <= '0;
            rx_sr      <= '0;
            rx_out     <= '0;
            bitcnt     <= '0;
            ecnt       <= '0;
            divcnt     <= '0;
            m_busy     <= 1'b0;
            sck_lvl    <= 1'b0;
            done_pulse <= 1'b0;
            ss_abort   <= 1'b0;
        end else begin
            done_pulse <= finish;
            ss_abort   <= slave_mode && !ctrl.ss_ign && ss_s && !ss_prev && (bitcnt != '0);
            if (ld && !busy) begin
                tx_sr <= ld_data;
                if (ctrl.master) begin
                    m_busy <= 1'b1;
                    ecnt   <= '0;
                    divcnt <= '0;
                    bitcnt <= '0;
                end
            end
            if (m_busy) begin
                divcnt <= tick ? '0 : divcnt + 1'b1;
                if (tick) begin
                    sck_lvl <= ~sck_lvl;
                    ecnt    <= ecnt + 1'b1;
                end
                if (finish) m_busy <= 1'b0;
            end
            if (shift_now) tx_sr <= {tx_sr[DW-2:0], 1'b0};
            if (sample_now) begin
                rx_sr  <= rx_next;
                bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
            end
            if (finish) rx_out <= sample_now ? rx_next : rx_sr;
            if (slave_mode && !selected) bitcnt <= '0;
        end
    end

    // R3: the master clock level only moves on a divider tick.
    assert_master_edges_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_busy && !tick && ctrl.en) |=> $stable(sck_lvl));

    // R4: a deselected slave starts every byte from bit zero.
    assert_slave_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !selected) |=> (bitcnt == '0));
endmodule

// File: rtl/spi_err_regs.sv
// Control register, status flags with their clear sequences, receive buffer
// and interrupt outputs. Assumes reg_rd and reg_wr are one-cycle strobes.
module spi_err_regs
    import spi_err_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ss_s,
    input  logic          busy,
    input  logic          done_pulse,
    input  logic          ss_abort,
    input  logic [DW-1:0] rx_in,
    output ctrl_t         ctrl,
    output logic          ld,
    output logic          irq_done,
    output logic          irq_err
);
    stat_t         st;
    logic [DW-1:0] rxbuf;
    logic arm_done, arm_mf, arm_wc;
    logic ctrl_wr, stat_rd, data_wr, data_acc, mf_hit;

    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign stat_rd  = reg_rd && (reg_sel == SEL_STAT);
    assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
    assign data_acc = (reg_wr || reg_rd) && (reg_sel == SEL_DATA);
    assign mf_hit   = ctrl.en && ctrl.master && !ctrl.ss_ign && !ss_s;
    assign ld       = data_wr;
    assign irq_done = st.done;
    assign irq_err  = st.mfault & ~ctrl.ss_ign;

    // Control register; a mode fault overrides enable and master.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata[4:0]);
            if (mf_hit) begin
                ctrl.en     <= 1'b0;
                ctrl.master <= 1'b0;
            end
        end
    end

    // Status flags, clear-sequence arming and receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= '0;
            rxbuf    <= '0;
            arm_done <= 1'b0;
            arm_mf   <= 1'b0;
            arm_wc   <= 1'b0;
        end else begin
            if (stat_rd) begin
                arm_done <= st.done;
                arm_mf   <= st.mfault;
                arm_wc   <= st.wcol;
            end
            if (data_acc) begin
                arm_done <= 1'b0;
                arm_wc   <= 1'b0;
            end
            if (ctrl_wr) arm_mf <= 1'b0;

            if (done_pulse)                st.done <= 1'b1;
            else if (data_acc && arm_done) st.done <= 1'b0;

            if (mf_hit)                    st.mfault <= 1'b1;
            else if (ctrl_wr && arm_mf)    st.mfault <= 1'b0;

            if (data_wr && busy)           st.wcol <= 1'b1;
            else if (data_acc && arm_wc)   st.wcol <= 1'b0;

            if (!ctrl.en)                  st.sserr <= 1'b0;
            else if (ss_abort)             st.sserr <= 1'b1;

            if (done_pulse && !st.done) rxbuf <= rx_in;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_sel)
            SEL_CTRL: reg_rdata = {{(DW-5){1'b0}}, ctrl};
            SEL_STAT: reg_rdata = {{(DW-4){1'b0}}, st};
            SEL_DATA: reg_rdata = rxbuf;
            default:  reg_rdata = '0;
        endcase
    end

    // R6: a mode fault leaves the controller disabled and out of master mode.
    assert_fault_disables_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.mfault) |-> (!ctrl.en && !ctrl.master));

    // R8: with the select pin ignored, no new mode fault appears.
    assert_masked_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ss_ign && !st.mfault) |=> !st.mfault);

    // R9: a data write during a transfer raises the collision flag.
    assert_collision_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> st.wcol);

    // R10: the deselect error survives while enable stays 1.
    assert_sserr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.en && st.sserr) |=> st.sserr);

    // R11: a byte completing while the flag is set leaves the buffer alone.
    assert_keep_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st.done && done_pulse) |=> $stable(rxbuf));
endmodule

// File: rtl/spi_err_ctrl.sv
// Top of the SPI controller: pin synchronizers, shift engine and registers.
// Assumes sck_i and ss_n_i are asynchronous; sdi is sampled only on clock edges.
module spi_err_ctrl
    import spi_err_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_HALF    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          sdi,
    output logic          sck_o,
    output logic          sdo,
    output logic          irq_done,
    output logic          irq_err
);
    ctrl_t         ctrl;
    logic [1:0]    pins_s;
    logic          busy, done_pulse, ss_abort, ld;
    logic [DW-1:0] rx_byte;

    spi_err_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i}), .q(pins_s)
    );

    spi_err_engine #(.DW(DW), .DIV_HALF(DIV_HALF)) u_engine (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ld(ld), .ld_data(reg_wdata),
        .sck_s(pins_s[0]), .ss_s(pins_s[1]), .sdi(sdi), .sck_o(sck_o), .sdo(sdo),
        .busy(busy), .done_pulse(done_pulse), .ss_abort(ss_abort), .rx_out(rx_byte)
    );

    spi_err_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_s(pins_s[1]), .busy(busy),
        .done_pulse(done_pulse), .ss_abort(ss_abort), .rx_in(rx_byte), .ctrl(ctrl),
        .ld(ld), .irq_done(irq_done), .irq_err(irq_err)
    );
endmodule

// File: tb/spi_err_ctrl_tb.sv
module spi_err_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 0, rst_n = 0;
    logic [1:0] reg_sel = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic sck_drv = 0, ss_drv = 1, sdi_drv = 0, loopback = 0;
    logic sck_o, sdo, irq_done, irq_err, sdi_w;
    int checks = 0, failures = 0;
    bit finished = 0;
    bit cur_cpol = 0, cur_cpha = 0;
    logic [7:0] mon = 0;
    logic sck_seen = 0;

    assign sdi_w = loopback ? sdo : sdi_drv;

    spi_err_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_i(sck_drv), .ss_n_i(ss_drv),
        .sdi(sdi_w), .sck_o(sck_o), .sdo(sdo), .irq_done(irq_done), .irq_err(irq_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor of master output: capture sdo on each sampling edge of sck_o.
    always @(negedge clk) begin
        if (sck_o != sck_seen && ((sck_o != cur_cpol) != cur_cpha))
            mon <= {mon[6:0], sdo};
        sck_seen <= sck_o;
    end

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk); reg_sel = sel; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] ctrl_val(bit en, bit m, bit pol, bit pha, bit ign);
        return {3'b0, ign, pha, pol, m, en};
    endfunction

    task automatic set_ctrl(bit en, bit m, bit pol, bit pha, bit ign);
        wr_reg(0, ctrl_val(en, m, pol, pha, ign));
        cur_cpol = pol; cur_cpha = pha;
        sck_drv = pol;
        waitc(4);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 200 && !irq_done; i++) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [7:0] v);
        loopback = 1;
        wr_reg(2, v);
        wait_done();
        waitc(2);
    endtask

    task automatic slave_shift(input logic [7:0] din, input int nbits, output logic [7:0] dout);
        dout = 0;
        for (int i = 0; i < nbits; i++) begin
            if (!cur_cpha) begin
                sdi_drv = din[7-i]; waitc(H);
                sck_drv = ~cur_cpol; dout = {dout[6:0], sdo}; waitc(H);
                sck_drv = cur_cpol;
            end else begin
                sck_drv = ~cur_cpol; sdi_drv = din[7-i]; waitc(H);
                sck_drv = cur_cpol; dout = {dout[6:0], sdo}; waitc(H);
            end
        end
        waitc(H);
    endtask

    task automatic slave_byte(input logic [7:0] txv, input logic [7:0] rxv, output logic [7:0] got);
        loopback = 0;
        wr_reg(2, txv);
        ss_drv = 0; waitc(H);
        slave_shift(rxv, 8, got);
        ss_drv = 1; waitc(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, got, v, txv;
        void'($urandom(32'd2718));
        waitc(3); rst_n = 1; waitc(2);

        // R1: reset state
        rd_reg(0, d); check(d == 0, "R1 ctrl", d, 0);
        rd_reg(1, d); check(d == 0, "R1 status", d, 0);
        rd_reg(2, d); check(d == 0, "R1 data", d, 0);
        check(!irq_done && !irq_err && !sck_o, "R1 outputs", {irq_done, irq_err, sck_o}, 0);

        // R2: control layout, upper bits dropped
        wr_reg(0, 8'hFF); rd_reg(0, d); check(d == 8'h1F, "R2 ctrl readback", d, 8'h1F);
        wr_reg(0, 8'h00); waitc(2);

        // R3/R5: master transfer, done needs status read first
        set_ctrl(1, 1, 0, 0, 0);
        master_xfer(8'hB4);
        check(mon == 8'hB4, "R3 msb-first sdo", mon, 8'hB4);
        check(irq_done, "R5 irq_done set", irq_done, 1);
        rd_reg(2, d); check(irq_done, "R5 data read alone keeps flag", irq_done, 1);
        rd_reg(1, d); check(d == 8'h01, "R5 status done", d, 8'h01);
        wr_reg(2, 8'h00); // clears done and starts a new byte
        check(!irq_done, "R5 data write clears", irq_done, 0);
        wait_done(); waitc(2);
        rd_reg(1, d); rd_reg(2, d); check(d == 8'h00, "R3 loopback zero", d, 0);
        check(!irq_done, "R5 data read clears", irq_done, 0);

        // R9: write collision
        loopback = 1;
        wr_reg(2, 8'hA5); waitc(5);
        wr_reg(2, 8'h3C);
        wait_done(); waitc(2);
        check(!irq_err, "R9 no error irq", irq_err, 0);
        check(mon == 8'hA5, "R9 byte unchanged on sdo", mon, 8'hA5);
        rd_reg(1, d); check(d == 8'h05, "R9 status done+wcol", d, 8'h05);
        rd_reg(2, d); check(d == 8'hA5, "R9 received original", d, 8'hA5);
        rd_reg(1, d); check(d == 8'h00, "R9 wcol cleared", d, 0);

        // R6/R7: mode fault
        ss_drv = 0; waitc(6);
        check(irq_err, "R6 irq_err", irq_err, 1);
        rd_reg(0, d); check(d == 8'h00, "R6 en/master cleared", d, 0);
        ss_drv = 1; waitc(4);
        wr_reg(0, 8'h00);
        check(irq_err, "R7 write alone keeps flag", irq_err, 1);
        rd_reg(1, d); check(d == 8'h02, "R7 status mfault", d, 8'h02);
        wr_reg(0, 8'h00); waitc(1);
        check(!irq_err, "R7 cleared irq", irq_err, 0);
        rd_reg(1, d); check(d == 8'h00, "R7 cleared status", d, 0);

        // R8: select ignored
        set_ctrl(1, 1, 1, 1, 1);
        ss_drv = 0; waitc(6);
        master_xfer(8'h96);
        check(!irq_err, "R8 no irq_err", irq_err, 0);
        rd_reg(0, d); check(d == 8'h1F, "R8 ctrl intact", d, 8'h1F);
        rd_reg(1, d); check(d == 8'h01, "R8 status done only", d, 8'h01);
        rd_reg(2, d); check(d == 8'h96, "R8 byte received", d, 8'h96);
        check(mon == 8'h96, "R8 sdo byte", mon, 8'h96);
        ss_drv = 1; waitc(4);

        // R10: deselect error
        set_ctrl(1, 0, 0, 0, 0);
        loopback = 0;
        ss_drv = 0; waitc(H); ss_drv = 1; waitc(H);
        rd_reg(1, d); check(d == 8'h00, "R10 no error at 0 bits", d, 0);
        ss_drv = 0; waitc(H);
        slave_shift(8'hE0, 3, got);
        ss_drv = 1; waitc(H);
        rd_reg(1, d); check(d == 8'h08, "R10 sserr set", d, 8'h08);
        check(!irq_err && !irq_done, "R10 no irq", {irq_err, irq_done}, 0);
        wr_reg(0, ctrl_val(1, 0, 0, 0, 0));
        rd_reg(1, d); check(d == 8'h08, "R10 sticky while enabled", d, 8'h08);
        wr_reg(0, 8'h00); waitc(1);
        rd_reg(1, d); check(d == 8'h00, "R10 cleared by enable 0", d, 0);

        // R11: overrun keeps first byte
        set_ctrl(1, 0, 0, 0, 0);
        slave_byte(8'h00, 8'h5A, got);
        slave_byte(8'h00, 8'hC3, got);
        rd_reg(1, d); check(d == 8'h01, "R11 no extra status", d, 8'h01);
        rd_reg(2, d); check(d == 8'h5A, "R11 first byte kept", d, 8'h5A);
        slave_byte(8'h00, 8'h81, got);
        rd_reg(1, d); rd_reg(2, d); check(d == 8'h81, "R11 next after clear", d, 8'h81);

        // R3/R4: random mix of modes and bytes
        for (int k = 0; k < 24; k++) begin
            bit pol, pha, is_m;
            pol = $urandom_range(0, 1); pha = $urandom_range(0, 1); is_m = $urandom_range(0, 1);
            v = 8'($urandom); txv = 8'($urandom);
            if (is_m) begin
                set_ctrl(1, 1, pol, pha, 0);
                master_xfer(v);
                check(mon == v, "R3 random sdo", mon, v);
                rd_reg(1, d); check(d == 8'h01, "R5 random done", d, 8'h01);
                rd_reg(2, d); check(d == v, "R3 random loopback", d, v);
            end else begin
                set_ctrl(1, 0, pol, pha, 0);
                slave_byte(txv, v, got);
                check(got == txv, "R4 random slave sdo", got, txv);
                rd_reg(1, d); check(d == 8'h01, "R5 random slave done", d, 8'h01);
                rd_reg(2, d); check(d == v, "R4 random slave rx", d, v);
            end
            check(!irq_done, "R5 random cleared", irq_done, 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule